// File: doc/BRIEF.md
# AXI Write/Read Demultiplexer with Per-ID Ordering

The block takes one AXI4 request stream and spreads it over `N` downstream ports. Each write address (AW) and read address (AR) arrives with a port select chosen outside the block. The block holds the request in a one-entry register and forwards it only when this cannot reorder responses. Responses that share an ID must all come back from one downstream port, so a request is held while the same ID, in the same direction, is still outstanding at a different port.

Tracking uses only the low `LookBits` bits of the ID. Writes and reads each have one counter per tracked ID, and each counter stores the port it is bound to. Write data beats have no port select of their own. They are steered by a small queue of AW selects kept in issue order.

Write responses (B) and read data (R) from the downstream ports are merged back round-robin. A read burst keeps its grant until its last beat.

Top module: `axi_id_demux`

## Requirements
- R1: `s_aw_ready` is high exactly when no AW is held. An AW accepted at a clock edge drives `m_aw_valid[sel]` (one-hot), `m_aw_id`, `m_aw_addr` and `m_aw_len` from that edge on, unless it is stalled. Once driven, it stays unchanged until `m_aw_ready[sel]` is high. The AR path (`s_ar_*`, `m_ar_*`) behaves the same way.
- R2: While reset is asserted and just after it: `s_aw_ready` and `s_ar_ready` are 1; `m_aw_valid`, `m_ar_valid`, `m_w_valid`, `s_b_valid` and `s_r_valid` are 0; `s_w_ready` is 0.
- R3: A held request is not forwarded while the counter for its tracked ID, in its own direction, is non-zero and bound to a different port. Writes and reads are tracked separately.
- R4: A held request is not forwarded while its counter already equals `MaxTrans`. Up to `MaxTrans` requests with one ID may be outstanding to one port.
- R5: A write counter decrements on each `s_b` handshake, indexed by the low bits of `s_b_id`. A read counter decrements on each `s_r` handshake with `s_r_last`, indexed by `s_r_id`. A request stalled only by that counter is forwarded in the cycle right after that handshake edge.
- R6: Each forwarded AW pushes its select into the W queue. W beats go only to the port at the queue head: `m_w_valid` = `s_w_valid` on that port, and `s_w_ready` = that port's `m_w_ready`. The head is popped on a W handshake with `s_w_last`. With the queue empty, `s_w_ready` is 0.
- R7: A held AW is not forwarded while the W queue holds `WDepth` entries, even in a cycle where the queue is popped.
- R8: B merging is round-robin. The search starts at the port after the last granted one, and port 0 is searched first after reset. `s_b_valid` is the OR of `m_b_valid`. `s_b_id` and `s_b_resp` come from the granted port, and only that port sees `m_b_ready` = `s_b_ready`. With all ports pending, each port is granted once in three consecutive handshakes.
- R9: R merging uses the same round-robin rule. After a beat without `last` is handshaked, the grant stays on that port until its last beat, so bursts never interleave.
- R10: ID bits above `LookBits` are ignored for tracking. With `LookBits` = 2, IDs 1 and 5 share a counter.
- R11: When a forward and a decrement hit one counter in the same cycle, the count is unchanged and the stored port is taken from the forwarded request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_aw_valid | input | 1 | Upstream write address valid |
| s_aw_ready | output | 1 | Upstream write address ready |
| s_aw_id | input | IdW | Write ID |
| s_aw_addr | input | AddrW | Write address |
| s_aw_len | input | LenW | Write burst length minus one |
| s_aw_sel | input | SelW | Target port for the write |
| s_w_valid | input | 1 | Upstream write data valid |
| s_w_ready | output | 1 | Upstream write data ready |
| s_w_data | input | DataW | Write data |
| s_w_last | input | 1 | Last write beat |
| s_b_valid | output | 1 | Merged write response valid |
| s_b_ready | input | 1 | Merged write response ready |
| s_b_id | output | IdW | Write response ID |
| s_b_resp | output | 2 | Write response code |
| s_ar_valid | input | 1 | Upstream read address valid |
| s_ar_ready | output | 1 | Upstream read address ready |
| s_ar_id | input | IdW | Read ID |
| s_ar_addr | input | AddrW | Read address |
| s_ar_len | input | LenW | Read burst length minus one |
| s_ar_sel | input | SelW | Target port for the read |
| s_r_valid | output | 1 | Merged read data valid |
| s_r_ready | input | 1 | Merged read data ready |
| s_r_id | output | IdW | Read data ID |
| s_r_data | output | DataW | Read data |
| s_r_resp | output | 2 | Read response code |
| s_r_last | output | 1 | Last read beat |
| m_aw_valid | output | N | Per-port write address valid |
| m_aw_ready | input | N | Per-port write address ready |
| m_aw_id | output | IdW | Forwarded write ID |
| m_aw_addr | output | AddrW | Forwarded write address |
| m_aw_len | output | LenW | Forwarded write length |
| m_w_valid | output | N | Per-port write data valid |
| m_w_ready | input | N | Per-port write data ready |
| m_w_data | output | DataW | Forwarded write data |
| m_w_last | output | 1 | Forwarded last flag |
| m_b_valid | input | N | Per-port write response valid |
| m_b_ready | output | N | Per-port write response ready |
| m_b_id | input | N*IdW | Per-port write response IDs |
| m_b_resp | input | N*2 | Per-port write response codes |
| m_ar_valid | output | N | Per-port read address valid |
| m_ar_ready | input | N | Per-port read address ready |
| m_ar_id | output | IdW | Forwarded read ID |
| m_ar_addr | output | AddrW | Forwarded read address |
| m_ar_len | output | LenW | Forwarded read length |
| m_r_valid | input | N | Per-port read data valid |
| m_r_ready | output | N | Per-port read data ready |
| m_r_id | input | N*IdW | Per-port read IDs |
| m_r_data | input | N*DataW | Per-port read data |
| m_r_resp | input | N*2 | Per-port read response codes |
| m_r_last | input | N | Per-port last flags |

## Verification
An AW or AR accepted upstream shows on the downstream port one edge later, in the cycle after the handshake. A counter or queue change takes effect in the cycle that follows its handshake edge, so a stall lifts in the cycle right after the releasing B or last R. W steering, B merging and R merging are combinational, so they are due in the same cycle. The bench drives inputs just after the rising edge and compares against its behavioural model at the falling edge. That way each expected value already reflects every register update from the preceding edge.

// File: rtl/axi_id_demux.sv
module axi_id_demux #(
  parameter int unsigned N        = 3,
  parameter int unsigned IdW      = 4,
  parameter int unsigned LookBits = 2,
  parameter int unsigned MaxTrans = 3,
  parameter int unsigned AddrW    = 16,
  parameter int unsigned DataW    = 16,
  parameter int unsigned LenW     = 8,
  parameter int unsigned WDepth   = 2,
  localparam int unsigned SelW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               s_aw_valid,
  output logic               s_aw_ready,
  input  logic [IdW-1:0]     s_aw_id,
  input  logic [AddrW-1:0]   s_aw_addr,
  input  logic [LenW-1:0]    s_aw_len,
  input  logic [SelW-1:0]    s_aw_sel,
  input  logic               s_w_valid,
  output logic               s_w_ready,
  input  logic [DataW-1:0]   s_w_data,
  input  logic               s_w_last,
  output logic               s_b_valid,
  input  logic               s_b_ready,
  output logic [IdW-1:0]     s_b_id,
  output logic [1:0]         s_b_resp,
  input  logic               s_ar_valid,
  output logic               s_ar_ready,
  input  logic [IdW-1:0]     s_ar_id,
  input  logic [AddrW-1:0]   s_ar_addr,
  input  logic [LenW-1:0]    s_ar_len,
  input  logic [SelW-1:0]    s_ar_sel,
  output logic               s_r_valid,
  input  logic               s_r_ready,
  output logic [IdW-1:0]     s_r_id,
  output logic [DataW-1:0]   s_r_data,
  output logic [1:0]         s_r_resp,
  output logic               s_r_last,
  output logic [N-1:0]       m_aw_valid,
  input  logic [N-1:0]       m_aw_ready,
  output logic [IdW-1:0]     m_aw_id,
  output logic [AddrW-1:0]   m_aw_addr,
  output logic [LenW-1:0]    m_aw_len,
  output logic [N-1:0]       m_w_valid,
  input  logic [N-1:0]       m_w_ready,
  output logic [DataW-1:0]   m_w_data,
  output logic               m_w_last,
  input  logic [N-1:0]       m_b_valid,
  output logic [N-1:0]       m_b_ready,
  input  logic [N*IdW-1:0]   m_b_id,
  input  logic [N*2-1:0]     m_b_resp,
  output logic [N-1:0]       m_ar_valid,
  input  logic [N-1:0]       m_ar_ready,
  output logic [IdW-1:0]     m_ar_id,
  output logic [AddrW-1:0]   m_ar_addr,
  output logic [LenW-1:0]    m_ar_len,
  input  logic [N-1:0]       m_r_valid,
  output logic [N-1:0]       m_r_ready,
  input  logic [N*IdW-1:0]   m_r_id,
  input  logic [N*DataW-1:0] m_r_data,
  input  logic [N*2-1:0]     m_r_resp,
  input  logic [N-1:0]       m_r_last
);
  localparam int unsigned NC    = 1 << LookBits;
  localparam int unsigned CntW  = $clog2(MaxTrans + 1);
  localparam int unsigned PtrW  = (WDepth > 1) ? $clog2(WDepth) : 1;
  localparam int unsigned QCntW = $clog2(WDepth + 1);

  function automatic logic [SelW-1:0] rr_pick(input logic [N-1:0] req, input logic [SelW-1:0] last);
    rr_pick = last;
    for (int k = int'(N); k >= 1; k--) begin
      if (req[SelW'((int'(last) + k) % int'(N))]) rr_pick = SelW'((int'(last) + k) % int'(N));
    end
  endfunction

  // held request registers
  logic aw_q, ar_q;
  logic [IdW-1:0] aw_id_q, ar_id_q;
  logic [AddrW-1:0] aw_addr_q, ar_addr_q;
  logic [LenW-1:0] aw_len_q, ar_len_q;
  logic [SelW-1:0] aw_sel_q, ar_sel_q;

  logic [CntW-1:0] wcnt [NC];
  logic [CntW-1:0] rcnt [NC];
  logic [SelW-1:0] wprt [NC];
  logic [SelW-1:0] rprt [NC];

  logic [SelW-1:0] wq [WDepth];
  logic [PtrW-1:0] wq_wr, wq_rd;
  logic [QCntW-1:0] wq_cnt;

  logic [SelW-1:0] b_ptr, b_pick, r_ptr, r_lk, r_sel;
  logic r_lock, r_any;

  wire [LookBits-1:0] aw_look = aw_id_q[LookBits-1:0];
  wire [LookBits-1:0] ar_look = ar_id_q[LookBits-1:0];
  wire [LookBits-1:0] b_look  = s_b_id[LookBits-1:0];
  wire [LookBits-1:0] r_look  = s_r_id[LookBits-1:0];

  wire aw_block = (wcnt[aw_look] != '0 && wprt[aw_look] != aw_sel_q) ||
                  wcnt[aw_look] == CntW'(MaxTrans) || wq_cnt == QCntW'(WDepth);
  wire ar_block = (rcnt[ar_look] != '0 && rprt[ar_look] != ar_sel_q) ||
                  rcnt[ar_look] == CntW'(MaxTrans);

  assign s_aw_ready = !aw_q;
  assign s_ar_ready = !ar_q;
  assign m_aw_valid = (aw_q && !aw_block) ? N'(1) << aw_sel_q : '0;
  assign m_ar_valid = (ar_q && !ar_block) ? N'(1) << ar_sel_q : '0;
  assign m_aw_id = aw_id_q;  assign m_aw_addr = aw_addr_q;  assign m_aw_len = aw_len_q;
  assign m_ar_id = ar_id_q;  assign m_ar_addr = ar_addr_q;  assign m_ar_len = ar_len_q;
  wire aw_fire = |(m_aw_valid & m_aw_ready);
  wire ar_fire = |(m_ar_valid & m_ar_ready);

  // W steering from the select queue
  wire [SelW-1:0] w_head = wq[wq_rd];
  wire w_has = wq_cnt != '0;
  assign m_w_valid = (s_w_valid && w_has) ? N'(1) << w_head : '0;
  assign s_w_ready = w_has && m_w_ready[w_head];
  assign m_w_data  = s_w_data;
  assign m_w_last  = s_w_last;
  wire w_pop = s_w_valid && s_w_ready && s_w_last;

  // B merge
  assign b_pick    = rr_pick(m_b_valid, b_ptr);
  assign s_b_valid = |m_b_valid;
  assign s_b_id    = m_b_id[b_pick*IdW +: IdW];
  assign s_b_resp  = m_b_resp[b_pick*2 +: 2];
  assign m_b_ready = (s_b_valid && s_b_ready) ? N'(1) << b_pick : '0;
  wire b_fire = s_b_valid && s_b_ready;

  // R merge, grant locked for the rest of a burst
  assign r_sel     = r_lock ? r_lk : rr_pick(m_r_valid, r_ptr);
  assign r_any     = r_lock ? m_r_valid[r_lk] : |m_r_valid;
  assign s_r_valid = r_any;
  assign s_r_id    = m_r_id[r_sel*IdW +: IdW];
  assign s_r_data  = m_r_data[r_sel*DataW +: DataW];
  assign s_r_resp  = m_r_resp[r_sel*2 +: 2];
  assign s_r_last  = m_r_last[r_sel];
  assign m_r_ready = (r_any && s_r_ready) ? N'(1) << r_sel : '0;
  wire r_fire = r_any && s_r_ready;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_q <= 1'b0; aw_id_q <= '0; aw_addr_q <= '0; aw_len_q <= '0; aw_sel_q <= '0;
      ar_q <= 1'b0; ar_id_q <= '0; ar_addr_q <= '0; ar_len_q <= '0; ar_sel_q <= '0;
    end else begin
      if (!aw_q) begin
        aw_q <= s_aw_valid;
        if (s_aw_valid) begin
          aw_id_q <= s_aw_id; aw_addr_q <= s_aw_addr; aw_len_q <= s_aw_len; aw_sel_q <= s_aw_sel;
        end
      end else if (aw_fire) aw_q <= 1'b0;
      if (!ar_q) begin
        ar_q <= s_ar_valid;
        if (s_ar_valid) begin
          ar_id_q <= s_ar_id; ar_addr_q <= s_ar_addr; ar_len_q <= s_ar_len; ar_sel_q <= s_ar_sel;
        end
      end else if (ar_fire) ar_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NC); i++) begin
        wcnt[i] <= '0; rcnt[i] <= '0; wprt[i] <= '0; rprt[i] <= '0;
      end
    end else begin
      for (int i = 0; i < int'(NC); i++) begin
        if (aw_fire && aw_look == LookBits'(i)) begin
          wprt[i] <= aw_sel_q;
          if (!(b_fire && b_look == LookBits'(i))) wcnt[i] <= wcnt[i] + 1'b1;
        end else if (b_fire && b_look == LookBits'(i)) wcnt[i] <= wcnt[i] - 1'b1;
        if (ar_fire && ar_look == LookBits'(i)) begin
          rprt[i] <= ar_sel_q;
          if (!(r_fire && s_r_last && r_look == LookBits'(i))) rcnt[i] <= rcnt[i] + 1'b1;
        end else if (r_fire && s_r_last && r_look == LookBits'(i)) rcnt[i] <= rcnt[i] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(WDepth); i++) wq[i] <= '0;
      wq_wr <= '0; wq_rd <= '0; wq_cnt <= '0;
      b_ptr <= SelW'(N - 1); r_ptr <= SelW'(N - 1); r_lock <= 1'b0; r_lk <= '0;
    end else begin
      if (aw_fire) begin
        wq[wq_wr] <= aw_sel_q;
        wq_wr <= (wq_wr == PtrW'(WDepth - 1)) ? '0 : wq_wr + 1'b1;
      end
      if (w_pop) wq_rd <= (wq_rd == PtrW'(WDepth - 1)) ? '0 : wq_rd + 1'b1;
      wq_cnt <= wq_cnt + QCntW'(aw_fire) - QCntW'(w_pop);
      if (b_fire) b_ptr <= b_pick;
      if (r_fire) begin
        r_ptr  <= r_sel;
        r_lk   <= r_sel;
        r_lock <= !s_r_last;
      end
    end
  end

  assert_aw_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_aw_valid != '0 && !aw_fire) |=> (m_aw_valid == $past(m_aw_valid) && $stable(m_aw_id)));
  assert_ar_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_ar_valid != '0 && !ar_fire) |=> (m_ar_valid == $past(m_ar_valid) && $stable(m_ar_id)));
  assert_w_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(m_w_valid) && $onehot0(m_aw_valid) && $onehot0(m_ar_valid));
  assert_b_grant_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(m_b_ready) && (m_b_ready & ~m_b_valid) == '0);
  assert_r_lock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_r_valid && s_r_ready && !s_r_last) |=> (m_r_ready == '0 || m_r_ready == $past(m_r_ready)));
  for (genvar g = 0; g < int'(NC); g++) begin : gen_cap
    assert_cnt_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wcnt[g] <= CntW'(MaxTrans) && rcnt[g] <= CntW'(MaxTrans));
  end
endmodule

// File: tb/sim_axi_id_demux.sv
module sim_axi_id_demux;
  localparam int N = 3, IdW = 4, L = 2, MT = 3, AW = 16, DW = 16, LW = 8, WD = 2, SW = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic s_aw_valid = 0, s_aw_ready; logic [IdW-1:0] s_aw_id = 0; logic [AW-1:0] s_aw_addr = 0;
  logic [LW-1:0] s_aw_len = 0; logic [SW-1:0] s_aw_sel = 0;
  logic s_w_valid = 0, s_w_ready, s_w_last = 0; logic [DW-1:0] s_w_data = 0;
  logic s_b_valid, s_b_ready = 1; logic [IdW-1:0] s_b_id; logic [1:0] s_b_resp;
  logic s_ar_valid = 0, s_ar_ready; logic [IdW-1:0] s_ar_id = 0; logic [AW-1:0] s_ar_addr = 0;
  logic [LW-1:0] s_ar_len = 0; logic [SW-1:0] s_ar_sel = 0;
  logic s_r_valid, s_r_ready = 1, s_r_last; logic [IdW-1:0] s_r_id; logic [DW-1:0] s_r_data; logic [1:0] s_r_resp;
  logic [N-1:0] m_aw_valid, m_aw_ready = '1, m_w_valid, m_w_ready = '1, m_b_valid = '0, m_b_ready;
  logic [N-1:0] m_ar_valid, m_ar_ready = '1, m_r_valid = '0, m_r_ready, m_r_last = '0;
  logic [IdW-1:0] m_aw_id, m_ar_id; logic [AW-1:0] m_aw_addr, m_ar_addr; logic [LW-1:0] m_aw_len, m_ar_len;
  logic [DW-1:0] m_w_data; logic m_w_last;
  logic [N*IdW-1:0] m_b_id = '0, m_r_id = '0; logic [N*2-1:0] m_b_resp = '0, m_r_resp = '0;
  logic [N*DW-1:0] m_r_data = '0;

  axi_id_demux #(.N(N), .IdW(IdW), .LookBits(L), .MaxTrans(MT), .AddrW(AW), .DataW(DW),
                 .LenW(LW), .WDepth(WD)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .s_aw_valid, .s_aw_ready, .s_aw_id, .s_aw_addr, .s_aw_len, .s_aw_sel,
    .s_w_valid, .s_w_ready, .s_w_data, .s_w_last,
    .s_b_valid, .s_b_ready, .s_b_id, .s_b_resp,
    .s_ar_valid, .s_ar_ready, .s_ar_id, .s_ar_addr, .s_ar_len, .s_ar_sel,
    .s_r_valid, .s_r_ready, .s_r_id, .s_r_data, .s_r_resp, .s_r_last,
    .m_aw_valid, .m_aw_ready, .m_aw_id, .m_aw_addr, .m_aw_len,
    .m_w_valid, .m_w_ready, .m_w_data, .m_w_last,
    .m_b_valid, .m_b_ready, .m_b_id, .m_b_resp,
    .m_ar_valid, .m_ar_ready, .m_ar_id, .m_ar_addr, .m_ar_len,
    .m_r_valid, .m_r_ready, .m_r_id, .m_r_data, .m_r_resp, .m_r_last);

  int errors = 0, checks = 0;
  bit started = 0, done = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  // downstream responders
  logic [N-1:0] b_en = '1, r_en = '1;
  int bid [N][16]; int bh [N], bt [N], wdone [N];
  int aid [N][16]; int alen [N][16]; int rh [N], rt [N], rbeat [N];

  // reference model
  bit haw = 0, har = 0; int haw_id, haw_sel, har_id, har_sel, har_len;
  int wc [4], wp [4], rc [4], rp [4];
  int wq [$];
  int bptr = N - 1, rptr = N - 1, rlk = 0; bit rlock = 0;

  function automatic int rr(input logic [N-1:0] req, input int last);
    for (int k = 1; k <= N; k++) if (req[(last + k) % N]) return (last + k) % N;
    return last;
  endfunction

  initial begin
    for (int i = 0; i < 4; i++) begin wc[i] = 0; wp[i] = 0; rc[i] = 0; rp[i] = 0; end
    for (int p = 0; p < N; p++) begin bh[p] = 0; bt[p] = 0; wdone[p] = 0; rh[p] = 0; rt[p] = 0; rbeat[p] = 0; end
  end

  always @(negedge clk) if (started) begin
    int l, eaw, ear, ew, bp, rpk, rbit, wport;
    bit ewr, ebv, erv, awf, arf, wfire, bf, rf;
    l = haw_id % 4;
    eaw = (haw && !((wc[l] != 0 && wp[l] != haw_sel) || wc[l] == MT || wq.size() == WD)) ? (1 << haw_sel) : 0;
    chk(m_aw_valid == eaw[N-1:0], "R1/R3/R4/R7 m_aw_valid", int'(m_aw_valid), eaw);
    if (eaw != 0) chk(m_aw_id == haw_id[IdW-1:0], "R1 m_aw_id", int'(m_aw_id), haw_id);
    chk(s_aw_ready == !haw, "R1 s_aw_ready", int'(s_aw_ready), int'(!haw));
    l = har_id % 4;
    ear = (har && !((rc[l] != 0 && rp[l] != har_sel) || rc[l] == MT)) ? (1 << har_sel) : 0;
    chk(m_ar_valid == ear[N-1:0], "R1/R3/R4 m_ar_valid", int'(m_ar_valid), ear);
    wport = (wq.size() > 0) ? wq[0] : 0;
    ew = (s_w_valid && wq.size() > 0) ? (1 << wport) : 0;
    ewr = (wq.size() > 0) && m_w_ready[wport];
    chk(m_w_valid == ew[N-1:0], "R6 m_w_valid", int'(m_w_valid), ew);
    chk(s_w_ready == ewr, "R6 s_w_ready", int'(s_w_ready), int'(ewr));
    ebv = |m_b_valid; bp = rr(m_b_valid, bptr);
    chk(s_b_valid == ebv, "R8 s_b_valid", int'(s_b_valid), int'(ebv));
    if (ebv) chk(s_b_id == m_b_id[bp*IdW +: IdW], "R8 s_b_id", int'(s_b_id), int'(m_b_id[bp*IdW +: IdW]));
    rpk = rlock ? rlk : rr(m_r_valid, rptr);
    erv = rlock ? m_r_valid[rlk] : |m_r_valid;
    chk(s_r_valid == erv, "R9 s_r_valid", int'(s_r_valid), int'(erv));
    if (erv) chk(s_r_data == m_r_data[rpk*DW +: DW], "R9 s_r_data", int'(s_r_data), int'(m_r_data[rpk*DW +: DW]));
    // model update for the coming edge
    awf = (eaw != 0) && m_aw_ready[haw_sel];
    arf = (ear != 0) && m_ar_ready[har_sel];
    wfire = s_w_valid && ewr;
    bf = ebv && s_b_ready;
    rf = erv && s_r_ready;
    if (wfire && s_w_last) begin wdone[wport]++; void'(wq.pop_front()); end
    if (awf) begin
      wc[haw_id % 4]++; wp[haw_id % 4] = haw_sel; wq.push_back(haw_sel);
      bid[haw_sel][bt[haw_sel] % 16] = haw_id; bt[haw_sel]++; haw = 0;
    end else if (!haw && s_aw_valid) begin haw = 1; haw_id = s_aw_id; haw_sel = s_aw_sel; end
    if (arf) begin
      rc[har_id % 4]++; rp[har_id % 4] = har_sel;
      aid[har_sel][rt[har_sel] % 16] = har_id; alen[har_sel][rt[har_sel] % 16] = har_len; rt[har_sel]++; har = 0;
    end else if (!har && s_ar_valid) begin har = 1; har_id = s_ar_id; har_sel = s_ar_sel; har_len = s_ar_len; end
    if (bf) begin
      wc[int'(m_b_id[bp*IdW +: IdW]) % 4]--; bptr = bp; bh[bp]++; wdone[bp]--;
    end
    if (rf) begin
      rbit = m_r_last[rpk];
      rptr = rpk; rlk = rpk; rlock = !rbit; rbeat[rpk]++;
      if (rbit) begin rc[int'(m_r_id[rpk*IdW +: IdW]) % 4]--; rh[rpk]++; rbeat[rpk] = 0; end
    end
  end

  always @(posedge clk) begin
    #1;
    for (int p = 0; p < N; p++) begin
      m_b_valid[p] = b_en[p] && (bt[p] > bh[p]) && wdone[p] > 0;
      m_b_id[p*IdW +: IdW] = IdW'(bid[p][bh[p] % 16]);
      m_r_valid[p] = r_en[p] && (rt[p] > rh[p]);
      m_r_id[p*IdW +: IdW] = IdW'(aid[p][rh[p] % 16]);
      m_r_data[p*DW +: DW] = DW'((p << 12) | rbeat[p]);
      m_r_last[p] = (rbeat[p] == alen[p][rh[p] % 16]);
    end
  end

  task automatic send_aw(input int id, input int sel);
    @(posedge clk); #1; s_aw_valid = 1; s_aw_id = IdW'(id); s_aw_sel = SW'(sel); s_aw_addr = AW'(id * 16);
    forever begin @(negedge clk); if (s_aw_ready) break; end
    @(posedge clk); #1; s_aw_valid = 0;
  endtask
  task automatic send_ar(input int id, input int sel, input int len);
    @(posedge clk); #1; s_ar_valid = 1; s_ar_id = IdW'(id); s_ar_sel = SW'(sel); s_ar_len = LW'(len);
    forever begin @(negedge clk); if (s_ar_ready) break; end
    @(posedge clk); #1; s_ar_valid = 0;
  endtask
  task automatic send_w(input int port);
    @(posedge clk); #1; s_w_valid = 1; s_w_last = 1; s_w_data = DW'(port + 100);
    forever begin @(negedge clk); if (s_w_ready) break; end
    chk(m_w_valid == N'(1 << port), "R6 W routed to queued port", int'(m_w_valid), 1 << port);
    @(posedge clk); #1; s_w_valid = 0; s_w_last = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(s_aw_ready && s_ar_ready, "R2 ready in reset", int'({s_aw_ready, s_ar_ready}), 3);
    chk(m_aw_valid == 0 && m_ar_valid == 0 && m_w_valid == 0, "R2 no valid in reset", int'(m_aw_valid), 0);
    chk(!s_b_valid && !s_r_valid && !s_w_ready, "R2 no response in reset", int'(s_b_valid), 0);
    @(posedge clk); #1; rst_n = 1; started = 1;

    // basic write
    send_aw(2, 1); send_w(1); idle(6);
    chk(wc[2] == 0, "R5 write counter released", wc[2], 0);

    // stall on same ID to other port
    b_en[0] = 0;
    send_aw(1, 0); send_w(0); send_aw(1, 1); idle(5);
    @(negedge clk); chk(m_aw_valid == 0, "R3 stall to other port", int'(m_aw_valid), 0);
    @(posedge clk); #1; b_en[0] = 1;
    begin
      int seen = 0;
      for (int c = 0; c < 20 && !seen; c++) begin @(negedge clk); if (m_aw_valid[1]) seen = 1; end
      chk(seen == 1, "R5 stall released after B", seen, 1);
    end
    send_w(1); idle(6);

    // aliasing on upper ID bits
    b_en[2] = 0;
    send_aw(1, 2); send_w(2); send_aw(5, 0); idle(4);
    @(negedge clk); chk(m_aw_valid == 0, "R10 aliased ID stalls", int'(m_aw_valid), 0);
    @(posedge clk); #1; b_en[2] = 1;
    send_w(0); idle(6);

    // MaxTrans cap
    b_en[1] = 0;
    for (int k = 0; k < MT; k++) begin send_aw(3, 1); send_w(1); end
    send_aw(3, 1); idle(4);
    @(negedge clk); chk(m_aw_valid == 0, "R4 cap reached", int'(m_aw_valid), 0);
    @(posedge clk); #1; b_en[1] = 1;
    send_w(1); idle(10);

    // W queue full
    send_aw(0, 0); send_aw(1, 1); send_aw(2, 2); idle(4);
    @(negedge clk); chk(m_aw_valid == 0, "R7 queue full holds AW", int'(m_aw_valid), 0);
    send_w(0); send_w(1); send_w(2); idle(8);

    // B round robin
    b_en = '0;
    send_aw(0, 0); send_w(0); send_aw(1, 1); send_w(1); send_aw(2, 2); send_w(2);
    @(posedge clk); #1; s_b_ready = 0; b_en = '1;
    idle(3);
    @(negedge clk); chk(m_b_valid == 3'b111, "R8 all pending", int'(m_b_valid), 7);
    @(posedge clk); #1; s_b_ready = 1;
    begin
      int mask = 0;
      for (int c = 0; c < 3; c++) begin @(negedge clk); if (s_b_valid) mask |= 1 << s_b_id; end
      chk(mask == 7, "R8 each port once in three grants", mask, 7);
    end
    idle(4);

    // read bursts, no interleave
    r_en = '0;
    send_ar(1, 1, 3); send_ar(2, 2, 2);
    @(posedge clk); #1; r_en = '1;
    begin
      int beats = 0, cur = -1, bad = 0;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        if (s_r_valid && s_r_ready) begin
          beats++;
          if (cur >= 0 && cur != int'(s_r_data[15:12])) bad++;
          cur = s_r_last ? -1 : int'(s_r_data[15:12]);
        end
      end
      chk(bad == 0, "R9 bursts not interleaved", bad, 0);
      chk(beats == 7, "R9 all read beats", beats, 7);
    end

    // read stall and independence from writes
    r_en[0] = 0;
    send_ar(3, 0, 0); send_ar(3, 2, 0); idle(3);
    @(negedge clk); chk(m_ar_valid == 0, "R3 read stall", int'(m_ar_valid), 0);
    send_aw(3, 1); idle(1);
    @(negedge clk); chk(wc[3] == 1, "R3 writes tracked apart from reads", wc[3], 1);
    @(posedge clk); #1; r_en[0] = 1;
    send_w(1); idle(10);

    // same-cycle increment and decrement
    b_en[0] = 0;
    send_aw(1, 0); send_w(0);
    @(posedge clk); #1; m_aw_ready[0] = 0; s_b_ready = 0;
    send_aw(1, 0);
    @(posedge clk); #1; b_en[0] = 1;
    begin
      int seen = 0;
      for (int c = 0; c < 20 && !seen; c++) begin @(negedge clk); if (s_b_valid) seen = 1; end
    end
    @(posedge clk); #1; s_b_ready = 1; m_aw_ready[0] = 1;
    @(posedge clk); #1; b_en[0] = 0;
    send_w(0);
    send_aw(1, 1); idle(4);
    @(negedge clk); chk(m_aw_valid == 0, "R11 count kept across same-cycle update", int'(m_aw_valid), 0);
    @(posedge clk); #1; b_en[0] = 1;
    send_w(1); idle(10);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule